// File: doc/BRIEF.md
# Dual-Input Up/Down Preset Counter

A binary counter whose direction is chosen by which of two count inputs pulses. One input counts up and the other counts down. A rising edge on the up input adds one to the count, and a rising edge on the down input subtracts one. Both count inputs are sampled on a single system clock, and their rising edges are found inside the block. The state register updates all of its bits at once, so the output never shows an intermediate value.

A level-sensitive preset loads the data inputs while the active-low load input is low. An active-high clear forces the count to zero and overrides everything else. Both controls act on the outputs in the same cycle and are held in the register from the next clock edge.

Two active-low outputs, carry and borrow, echo the low phase of the matching count input while the count sits at its top or bottom value. A second counter can take carry on its up input and borrow on its down input with no extra logic, which builds longer words. Loading a start value turns the counter into a modulo-N divider.

Top module: `dual_clk_updown_cnt`

## Requirements
- R1: With the down input held high and load and clear inactive, a rising edge on up_i raises count_o by one. The new value shows from the clock edge that samples up_i high.
- R2: With the up input held high and load and clear inactive, a rising edge on dn_i lowers count_o by one.
- R3: A rising edge on one count input while the other count input is low leaves the count unchanged.
- R4: While load_ni is low and clr_i is low, count_o equals data_i in the same cycle, and count edges are ignored. After load_ni returns high, the loaded value stays.
- R5: While clr_i is high, count_o is zero in the same cycle, whatever load_ni, data_i and the count inputs do. After clr_i falls, the count stays zero.
- R6: Counting up from the all-ones value gives zero, and counting down from zero gives the all-ones value.
- R7: carry_no is low exactly when up_i is low and count_o is all ones (15 at the default width). Otherwise it is high.
- R8: borrow_no is low exactly when dn_i is low and count_o is zero. Otherwise it is high.
- R9: Reset clears the count and sets both edge-history bits high. A count input that is already high when reset is released causes no count, while a later rising edge does.
- R10: When a second counter takes carry_no on its up input and borrow_no on its down input, it counts up once on each up-wrap of the first counter and down once on each down-wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Count-up input; counts on a rising edge |
| dn_i | input | 1 | Count-down input; counts on a rising edge |
| load_ni | input | 1 | Preset enable, active low, level sensitive |
| clr_i | input | 1 | Clear, active high, overrides all others |
| data_i | input | W | Preset value |
| count_o | output | W | Current count |
| carry_no | output | 1 | Overflow pulse, active low |
| borrow_no | output | 1 | Underflow pulse, active low |

## Verification
The step properties expect each count input to stay at one level for at least one full system clock between transitions, so that every pulse edge is sampled. They also keep their own edge history, which starts high at reset, as the design's does. The stimulus changes inputs only at falling clock edges and holds every level for one or more whole cycles. It keeps the idle count input high while the other one pulses, except in the deliberate protocol-violation phase. Clear and load are applied both with and without count pulses inside the same window.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  localparam int unsigned CH_UP = 0;
  localparam int unsigned CH_DN = 1;
  localparam int unsigned N_CH  = 2;
endpackage

// File: rtl/cnt_edge_det.sv
module cnt_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] hist_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    // history resets high so a level already high at release is not an edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[g] <= 1'b1;
      else         hist_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~hist_q[g];
  end
endmodule

// File: rtl/cnt_step_dec.sv
module cnt_step_dec
  import cnt_pkg::*;
(
  input  logic [N_CH-1:0] lvl_i,
  input  logic [N_CH-1:0] rise_i,
  input  logic            load_ni,
  input  logic            clr_i,
  output step_e           step_o
);
  logic up_ok, dn_ok, ctl_idle;

  assign ctl_idle = load_ni & ~clr_i;
  // an edge counts only while the other input is high and not rising itself
  assign up_ok = rise_i[CH_UP] & lvl_i[CH_DN] & ~rise_i[CH_DN];
  assign dn_ok = rise_i[CH_DN] & lvl_i[CH_UP] & ~rise_i[CH_UP];

  always_comb begin
    step_o = STEP_HOLD;
    if (ctl_idle) begin
      if (up_ok)      step_o = STEP_UP;
      else if (dn_ok) step_o = STEP_DN;
    end
  end
endmodule

// File: rtl/cnt_core.sv
module cnt_core
  import cnt_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  step_e        step_i,
  input  logic         load_ni,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case (step_i)
      STEP_UP: cnt_d = cnt_q + ONE;
      STEP_DN: cnt_d = cnt_q - ONE;
      default: cnt_d = cnt_q;
    endcase
    if (!load_ni) cnt_d = data_i;
    if (clr_i)    cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // level controls reach the output in the same cycle
  always_comb begin
    if (clr_i)         count_o = '0;
    else if (!load_ni) count_o = data_i;
    else               count_o = cnt_q;
  end
endmodule

// File: rtl/cnt_cascade.sv
module cnt_cascade #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] count_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic         carry_no,
  output logic         borrow_no
);
  logic at_top, at_bot;

  assign at_top    = &count_i;
  assign at_bot    = ~|count_i;
  assign carry_no  = ~(at_top & ~up_i);
  assign borrow_no = ~(at_bot & ~dn_i);
endmodule

// File: rtl/dual_clk_updown_cnt.sv
module dual_clk_updown_cnt
  import cnt_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         load_ni,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic         carry_no,
  output logic         borrow_no
);
  logic [N_CH-1:0] lvl, rise;
  step_e           step;

  assign lvl[CH_UP] = up_i;
  assign lvl[CH_DN] = dn_i;

  cnt_edge_det #(.N(N_CH)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  cnt_step_dec u_dec (
    .lvl_i   (lvl),
    .rise_i  (rise),
    .load_ni (load_ni),
    .clr_i   (clr_i),
    .step_o  (step)
  );

  cnt_core #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .load_ni (load_ni),
    .clr_i   (clr_i),
    .data_i  (data_i),
    .count_o (count_o)
  );

  cnt_cascade #(.W(W)) u_casc (
    .count_i   (count_o),
    .up_i      (up_i),
    .dn_i      (dn_i),
    .carry_no  (carry_no),
    .borrow_no (borrow_no)
  );
endmodule

// File: rtl/cnt_chk.sv
module cnt_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         up_i,
  input logic         dn_i,
  input logic         load_ni,
  input logic         clr_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] count_o,
  input logic         carry_no,
  input logic         borrow_no
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic up_h, dn_h;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_h <= 1'b1;
      dn_h <= 1'b1;
    end else begin
      up_h <= up_i;
      dn_h <= dn_i;
    end
  end

  logic idle, up_e, dn_e;
  assign idle = load_ni & ~clr_i;
  assign up_e = up_i & ~up_h;
  assign dn_e = dn_i & ~dn_h;

  // R1, R6
  a_r1_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && up_e && dn_i && !dn_e) |=>
      (clr_i || !load_ni || count_o == $past(count_o) + ONE));

  // R2, R6
  a_r2_dn_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && dn_e && up_i && !up_e) |=>
      (clr_i || !load_ni || count_o == $past(count_o) - ONE));

  // R3
  a_r3_no_count_on_violation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && up_e && !dn_i) |=> (clr_i || !load_ni || $stable(count_o)));

  // R5
  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (count_o == '0));

  a_r5_clear_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (clr_i || !load_ni || count_o == '0));

  // R4
  a_r4_load_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && !clr_i) |=> (clr_i || !load_ni || count_o == $past(data_i)));

  // R7
  a_r7_carry_low_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (!up_i && count_o == TOP));
  a_r7_carry_low_when: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && count_o == TOP) |-> !carry_no);

  // R8
  a_r8_borrow_low_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |-> (!dn_i && count_o == '0));
  a_r8_borrow_low_when: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dn_i && count_o == '0) |-> !borrow_no);
endmodule

bind dual_clk_updown_cnt cnt_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .up_i      (up_i),
  .dn_i      (dn_i),
  .load_ni   (load_ni),
  .clr_i     (clr_i),
  .data_i    (data_i),
  .count_o   (count_o),
  .carry_no  (carry_no),
  .borrow_no (borrow_no)
);

// File: tb/dual_clk_updown_cnt_tb.sv
module dual_clk_updown_cnt_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b1, dn = 1'b1, ld_n = 1'b1, clr = 1'b0;
  logic [3:0] dat = 4'd0;
  logic [3:0] cnt0, cnt1;
  logic car0, bor0, car1, bor1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_clk_updown_cnt #(.W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn), .load_ni(ld_n),
    .clr_i(clr), .data_i(dat), .count_o(cnt0), .carry_no(car0), .borrow_no(bor0)
  );

  // R10: second stage fed by carry and borrow
  dual_clk_updown_cnt #(.W(4)) u_dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .up_i(car0), .dn_i(bor0), .load_ni(1'b1),
    .clr_i(clr), .data_i(4'd0), .count_o(cnt1), .carry_no(car1), .borrow_no(bor1)
  );

  int m_cnt[2];
  bit m_hu[2];
  bit m_hd[2];

  task automatic model_reset();
    for (int s = 0; s < 2; s++) begin
      m_cnt[s] = 0; m_hu[s] = 1'b1; m_hd[s] = 1'b1;
    end
  endtask

  task automatic model_clock(input int s, input bit uu, dd, ll, cc, input int dv);
    bit ru, rd;
    ru = uu && !m_hu[s];
    rd = dd && !m_hd[s];
    if (cc) m_cnt[s] = 0;
    else if (!ll) m_cnt[s] = dv;
    else if (ru && dd && !rd) m_cnt[s] = (m_cnt[s] + 1) % 16;
    else if (rd && uu && !ru) m_cnt[s] = (m_cnt[s] + 15) % 16;
    m_hu[s] = uu;
    m_hd[s] = dd;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit u, d, ln, c, input int dv, input string tag);
    int e0, e1;
    bit ec0, eb0, ec1, eb1;
    @(negedge clk);
    up = u; dn = d; ld_n = ln; clr = c; dat = dv[3:0];
    #2;
    e0  = c ? 0 : (!ln ? dv : m_cnt[0]);
    ec0 = !(!u && e0 == 15);
    eb0 = !(!d && e0 == 0);
    e1  = c ? 0 : m_cnt[1];
    ec1 = !(!ec0 && e1 == 15);
    eb1 = !(!eb0 && e1 == 0);
    chk(tag, cnt0, e0);
    chk("R7", car0, ec0);
    chk("R8", bor0, eb0);
    chk("R10", cnt1, e1);
    chk("R10", car1, ec1);
    chk("R10", bor1, eb1);
    if (rst_n) begin
      model_clock(0, u, d, ln, c, dv);
      model_clock(1, ec0, eb0, 1'b1, c, 0);
    end
  endtask

  task automatic pulse_up(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b1, 1'b1, 1'b0, 0, tag);
      step(1'b1, 1'b1, 1'b1, 1'b0, 0, tag);
    end
  endtask

  task automatic pulse_dn(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0, 0, tag);
      step(1'b1, 1'b1, 1'b1, 1'b0, 0, tag);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    // R9: reset state with inputs high, then release
    rst_n = 1'b0;
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R9");
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R9");
    // R1: count up
    pulse_up(5, "R1");
    // R2: count down
    pulse_dn(3, "R2");
    // R4: preset with a count pulse inside the load window
    step(1'b1, 1'b1, 1'b0, 1'b0, 13, "R4");
    step(1'b0, 1'b1, 1'b0, 1'b0, 9, "R4");
    step(1'b1, 1'b1, 1'b0, 1'b0, 13, "R4");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R4");
    // R6, R7, R10: wrap upward through carry
    pulse_up(4, "R6");
    pulse_up(17, "R10");
    // R6, R8, R10: wrap downward through borrow
    pulse_dn(3, "R6");
    pulse_dn(18, "R10");
    // R3: edges while the other input is low
    step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, 0, "R3");
    step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R3");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R3");
    step(1'b0, 1'b1, 1'b1, 1'b0, 0, "R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, 0, "R3");
    step(1'b0, 1'b1, 1'b1, 1'b0, 0, "R3");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R3");
    // R5: clear overrides load, data and counting
    pulse_up(3, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b1, 7, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b1, 7, "R5");
    step(1'b1, 1'b1, 1'b1, 1'b1, 0, "R5");
    step(1'b1, 1'b0, 1'b1, 1'b1, 0, "R5");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R5");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R5");
    // R4: modulo-5 divider via preset of 11 and counting up to wrap
    step(1'b1, 1'b1, 1'b0, 1'b0, 11, "R4");
    pulse_up(7, "R4");
    // R9: reset released with up low, then a true rising edge counts
    @(negedge clk); rst_n = 1'b0; model_reset();
    step(1'b0, 1'b1, 1'b1, 1'b0, 0, "R9");
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b0, 0, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R9");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule